// File: doc/BRIEF.md
# Multi-Bank Level Interrupt Controller

The controller gathers level-sensitive interrupt lines, arranged in banks of 32, and presents them to a processor as two request outputs. One output is the normal request and the other is the fast request. Each line has a 6-bit priority and a route bit that sends it to one class or the other. A line is pending while its live input is high or while its software-set bit is set. A pending line that is not masked is a candidate for its class. The winning candidate is the one with the numerically lowest priority. When priorities tie, the highest line number wins.

Each output follows an arm-and-fire handshake. An armed output with at least one candidate, and with the global mask clear, rises and captures the winner's line number as its code. It then stays high, and the code stays frozen, until software writes the re-arm bit for that class. A 4 KB window of 32-bit words holds the register file:
- global registers: revision, system config with soft reset, status, the two codes, control, protection and idle;
- per-bank registers: raw input, mask with atomic clear and set aliases, software set and clear, and the two class-filtered pending views;
- one config word per line.

Bus accesses take one cycle. A write takes effect at the clock edge. Read data is combinational while `bus_en` is high and `bus_we` is low.

Top module: `mbk_intc`

## Requirements
- R1: After reset, both outputs are low and both codes read 0. Every bank mask reads 0xFFFFFFFF and every line config reads 0. Address 0x000 reads 0x21 and 0x014 reads 1.
- R2: Each bank's raw-input word reads the source lines as sampled at the previous clock edge. It is at 0x080+0x20·b+0x00, with bit n being line 32·b+n. Pending is raw input OR software bits. A write at +0x10 sets software bits. A write at +0x14 clears software bits and reads 0.
- R3: The pending IRQ view at +0x18 reads pending AND NOT mask AND NOT route. The pending FIQ view at +0x1C reads pending AND NOT mask AND route.
- R4: A write at +0x04 loads the mask. A write at +0x08 clears the mask bits written as 1. A write at +0x0C sets the mask bits written as 1. The +0x08 and +0x0C addresses read 0.
- R5: The config of line n in bank b is at 0x100+0x80·b+4·n. Bits 7:2 hold the priority and bit 0 holds the route (1 = FIQ class). Bit 1 and bits above 7 read 0.
- R6: When an output is armed, its class has a candidate and the global mask is clear, the output rises at the next edge. At that edge the code latches the winner's line number. The IRQ code reads at 0x040 and the FIQ code reads at 0x044.
- R7: The winner is the candidate with the lowest priority value. On a tie, the highest line number wins.
- R8: A fired output stays high and its code holds until a control write at 0x048 sets bit 0 (IRQ) or bit 1 (FIQ). That write drops the output at its edge and re-arms the output, so the output may fire again one edge later.
- R9: Control bit 2 is the global mask. While it is set, neither output rises. It reads back in bit 2 of 0x048.
- R10: A write to 0x010 with bit 1 set restores the reset state of every register, output and code.
- R11: Reading the code registers has no side effect. Writes to read-only addresses are ignored. Bank index 3 (0x0E0–0x0FF), line configs past the last bank, and unmapped addresses read 0 and ignore writes.
- R12: Bit 0 of 0x010 reads back as written. The idle word at 0x050 keeps 2 bits. Protection at 0x04C always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address; bits 1:0 ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; 0 when no read is in progress |
| src_lines | input | 96 | Level interrupt sources, line 32·b+n |
| irq_out | output | 1 | Normal-class request |
| fiq_out | output | 1 | Fast-class request |

## Verification
The bench targets these corner cases, each with the failure it would expose:
- **Priority ties between lines in different banks.** A resolver that kept the first match would report the lower line.
- **Software-clear recompute.** Recomputing pending as AND instead of OR would lose lines whose input is still high.
- **Re-arm while the global mask is set.** A design that ignored the global mask would fire immediately.
- **The mask-set alias.** A design that fed it into output evaluation or into the full mask load would corrupt the other mask bits.

Writes to bank index 3, to read-only words and to the code registers are checked through readback: a decoder that aliased bank 3 onto bank 0 or cleared a code on read shows up there. A randomized phase sweeps the masks, routes, small priorities and sparse software bits, then compares both pending views and the winner of each class.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned BUS_AW = 12;
  localparam int unsigned BUS_DW = 32;

  // word offsets inside the global page
  localparam logic [BUS_AW-1:0] G_REV      = 12'h000;
  localparam logic [BUS_AW-1:0] G_SYSCFG   = 12'h010;
  localparam logic [BUS_AW-1:0] G_STATUS   = 12'h014;
  localparam logic [BUS_AW-1:0] G_CODE_IRQ = 12'h040;
  localparam logic [BUS_AW-1:0] G_CODE_FIQ = 12'h044;
  localparam logic [BUS_AW-1:0] G_CTRL     = 12'h048;
  localparam logic [BUS_AW-1:0] G_PROT     = 12'h04C;
  localparam logic [BUS_AW-1:0] G_IDLE     = 12'h050;

  localparam int unsigned BANK_BASE = 'h080;
  localparam int unsigned CFG_BASE  = 'h100;
  localparam int unsigned CFG_STRIDE = 'h80;

  // word select inside one bank page
  typedef enum logic [2:0] {
    BK_RAW  = 3'd0,
    BK_MASK = 3'd1,
    BK_MCLR = 3'd2,
    BK_MSET = 3'd3,
    BK_SSET = 3'd4,
    BK_SCLR = 3'd5,
    BK_PIRQ = 3'd6,
    BK_PFIQ = 3'd7
  } bank_word_e;

  // class index for the two request outputs
  localparam int unsigned CLS_IRQ = 0;
  localparam int unsigned CLS_FIQ = 1;

  // priority comparison: lower value is more urgent; equal lets the later
  // scanned (higher numbered) line take over
  function automatic logic takes_over(input logic [7:0] p_new, input logic [7:0] p_best);
    return p_new <= p_best;
  endfunction

  // mask update for the three mask words
  function automatic logic [31:0] mask_next(input bank_word_e w, input logic [31:0] cur,
                                            input logic [31:0] wd);
    case (w)
      BK_MASK: return wd;
      BK_MCLR: return cur & ~wd;
      BK_MSET: return cur | wd;
      default: return cur;
    endcase
  endfunction

  // class filter for pending views
  function automatic logic [31:0] class_view(input logic [31:0] pend, input logic [31:0] msk,
                                             input logic [31:0] rte, input logic fast);
    return pend & ~msk & (fast ? rte : ~rte);
  endfunction
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int unsigned NBANK = 3,
  parameter int unsigned LPB   = 32,
  parameter int unsigned PW    = 6,
  parameter logic [7:0]  REV   = 8'h21,
  localparam int unsigned NLINE = NBANK * LPB,
  localparam int unsigned CW    = $clog2(NLINE)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_en,
  input  logic                       bus_we,
  input  logic [BUS_AW-1:0]          bus_addr,
  input  logic [BUS_DW-1:0]          bus_wdata,
  output logic [BUS_DW-1:0]          bus_rdata,
  input  logic [NLINE-1:0]           lines_in,
  input  logic [CW-1:0]              code_irq,
  input  logic [CW-1:0]              code_fiq,
  output logic [NLINE-1:0]           mask_flat,
  output logic [NLINE-1:0]           pend_flat,
  output logic [NLINE-1:0]           route_flat,
  output logic [NLINE-1:0][PW-1:0]   prio_flat,
  output logic                       gmask,
  output logic [1:0]                 rearm,
  output logic                       soft_rst
);
  localparam int unsigned BW      = (NBANK > 1) ? $clog2(NBANK) : 1;
  localparam int unsigned CFG_END = CFG_BASE + NBANK * CFG_STRIDE;

  logic [NBANK-1:0][LPB-1:0] raw_q, mask_q, swi_q;
  logic [NLINE-1:0][PW-1:0]  prio_q;
  logic [NLINE-1:0]          route_q;
  logic                      gmask_q, autoidle_q;
  logic [1:0]                idle_q;

  // ---------------- address decode ----------------
  logic [BUS_AW-1:0] a;
  logic              wr, rd, in_glob, in_bank, bank_ok, in_cfg, cfg_ok;
  logic [1:0]        bsel;
  logic [BW-1:0]     bidx;
  bank_word_e        bword;
  logic [BUS_AW-1:0] cfg_off;
  logic [4:0]        cfg_b;
  logic [4:0]        cfg_n;
  logic [CW-1:0]     cfg_line;
  logic [LPB-1:0]    wd;

  assign a       = {bus_addr[BUS_AW-1:2], 2'b00};
  assign wr      = bus_en & bus_we;
  assign rd      = bus_en & ~bus_we;
  assign in_glob = (a[11:7] == 5'd0);
  assign in_bank = (a[11:7] == 5'd1);
  assign bsel    = a[6:5];
  assign bidx    = BW'(bsel);
  assign bank_ok = in_bank && (32'(bsel) < NBANK);
  assign bword   = bank_word_e'(a[4:2]);
  assign cfg_off = a - BUS_AW'(CFG_BASE);
  assign in_cfg  = (32'(a) >= CFG_BASE) && (32'(a) < CFG_END);
  assign cfg_b   = cfg_off[11:7];
  assign cfg_n   = cfg_off[6:2];
  assign cfg_ok  = in_cfg && (32'(cfg_n) < LPB);
  assign cfg_line = CW'(32'(cfg_b) * LPB + 32'(cfg_n));
  assign wd      = bus_wdata[LPB-1:0];

  // internal events brought out for the output control and the assertions
  assign soft_rst = wr && in_glob && (a == G_SYSCFG) && bus_wdata[1];
  assign rearm    = (wr && in_glob && (a == G_CTRL)) ? bus_wdata[1:0] : 2'b00;

  // ---------------- per-bank storage ----------------
  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic hit;
    assign hit = wr && bank_ok && (bsel == 2'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        raw_q[b] <= '0;
      end else begin
        raw_q[b] <= lines_in[b*LPB +: LPB];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mask_q[b] <= '1;
        swi_q[b]  <= '0;
      end else if (soft_rst) begin
        mask_q[b] <= '1;
        swi_q[b]  <= '0;
      end else if (hit) begin
        mask_q[b] <= LPB'(mask_next(bword, 32'(mask_q[b]), 32'(wd)));
        if (bword == BK_SSET) swi_q[b] <= swi_q[b] | wd;
        if (bword == BK_SCLR) swi_q[b] <= swi_q[b] & ~wd;
      end
    end

    // level pending: live input or software set
    assign pend_flat[b*LPB +: LPB] = raw_q[b] | swi_q[b];
    assign mask_flat[b*LPB +: LPB] = mask_q[b];
  end

  // ---------------- per-line config ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q  <= '0;
      route_q <= '0;
    end else if (soft_rst) begin
      prio_q  <= '0;
      route_q <= '0;
    end else if (wr && cfg_ok) begin
      prio_q[cfg_line]  <= bus_wdata[PW+1:2];
      route_q[cfg_line] <= bus_wdata[0];
    end
  end

  assign route_flat = route_q;
  assign prio_flat  = prio_q;

  // ---------------- global words ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gmask_q    <= 1'b0;
      autoidle_q <= 1'b0;
      idle_q     <= 2'b00;
    end else if (soft_rst) begin
      gmask_q    <= 1'b0;
      autoidle_q <= 1'b0;
      idle_q     <= 2'b00;
    end else if (wr && in_glob) begin
      case (a)
        G_SYSCFG: autoidle_q <= bus_wdata[0];
        G_CTRL:   gmask_q    <= bus_wdata[2];
        G_IDLE:   idle_q     <= bus_wdata[1:0];
        default:  ;
      endcase
    end
  end

  assign gmask = gmask_q;

  // ---------------- read mux ----------------
  logic [LPB-1:0] rte_bank;
  assign rte_bank = route_q[32'(bidx) * LPB +: LPB];

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (in_glob) begin
        case (a)
          G_REV:      bus_rdata = 32'(REV);
          G_SYSCFG:   bus_rdata = 32'(autoidle_q);
          G_STATUS:   bus_rdata = 32'd1;
          G_CODE_IRQ: bus_rdata = 32'(code_irq);
          G_CODE_FIQ: bus_rdata = 32'(code_fiq);
          G_CTRL:     bus_rdata = {29'd0, gmask_q, 2'b00};
          G_IDLE:     bus_rdata = 32'(idle_q);
          default:    bus_rdata = '0;
        endcase
      end else if (bank_ok) begin
        case (bword)
          BK_RAW:  bus_rdata = 32'(raw_q[bidx]);
          BK_MASK: bus_rdata = 32'(mask_q[bidx]);
          BK_SSET: bus_rdata = 32'(swi_q[bidx]);
          BK_PIRQ: bus_rdata = class_view(32'(raw_q[bidx] | swi_q[bidx]), 32'(mask_q[bidx]),
                                          32'(rte_bank), 1'b0);
          BK_PFIQ: bus_rdata = class_view(32'(raw_q[bidx] | swi_q[bidx]), 32'(mask_q[bidx]),
                                          32'(rte_bank), 1'b1);
          default: bus_rdata = '0;
        endcase
      end else if (cfg_ok) begin
        bus_rdata = 32'({prio_q[cfg_line], 1'b0, route_q[cfg_line]});
      end
    end
  end

  logic unused_bits;
  assign unused_bits = ^{bus_addr[1:0], bus_wdata};

  // a mask-set write may only add mask bits
  logic mset_wr;
  assign mset_wr = wr && bank_ok && (bword == BK_MSET);

  assert_mset_only_adds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mset_wr |=> ((mask_flat & $past(mask_flat)) == $past(mask_flat)));

  assert_softreset_restores_R10: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> ((&mask_flat) && !gmask && (route_flat == '0)));
endmodule

// File: rtl/intc_resolver.sv
module intc_resolver
  import intc_pkg::*;
#(
  parameter int unsigned NLINE = 96,
  parameter int unsigned PW    = 6,
  localparam int unsigned CW   = $clog2(NLINE)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NLINE-1:0]         cand,
  input  logic [NLINE-1:0][PW-1:0] prio,
  output logic                     any,
  output logic [CW-1:0]            win
);
  logic [PW-1:0] best_p;

  // ascending scan; an equal priority later in the scan replaces the holder
  always_comb begin
    any    = 1'b0;
    win    = '0;
    best_p = '1;
    for (int i = 0; i < NLINE; i++) begin
      if (cand[i] && (!any || takes_over(8'(prio[i]), 8'(best_p)))) begin
        any    = 1'b1;
        best_p = prio[i];
        win    = CW'(i);
      end
    end
  end

  assert_win_is_candidate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> cand[win]);

  assert_none_means_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cand == '0) |-> !any);
endmodule

// File: rtl/intc_outctl.sv
module intc_outctl #(
  parameter int unsigned CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          rearm,
  input  logic          gmask,
  input  logic          any,
  input  logic [CW-1:0] win,
  output logic          out_q,
  output logic [CW-1:0] code_q
);
  logic armed_q;
  logic fire;

  assign fire = armed_q && any && !gmask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      out_q   <= 1'b0;
      code_q  <= '0;
    end else if (soft_rst) begin
      armed_q <= 1'b1;
      out_q   <= 1'b0;
      code_q  <= '0;
    end else if (rearm) begin
      armed_q <= 1'b1;
      out_q   <= 1'b0;
    end else if (fire) begin
      armed_q <= 1'b0;
      out_q   <= 1'b1;
      code_q  <= win;
    end
  end

  assert_rise_needs_candidate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_q) |-> $past(any));

  assert_gmask_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    gmask |=> !$rose(out_q));

  assert_code_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q && $past(out_q)) |-> $stable(code_q));

  assert_rearm_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> !out_q);
endmodule

// File: rtl/mbk_intc.sv
module mbk_intc
  import intc_pkg::*;
#(
  parameter int unsigned NBANK = 3,
  parameter int unsigned LPB   = 32,
  parameter int unsigned PW    = 6,
  parameter logic [7:0]  REV   = 8'h21,
  localparam int unsigned NLINE = NBANK * LPB,
  localparam int unsigned CW    = $clog2(NLINE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [11:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NLINE-1:0]  src_lines,
  output logic              irq_out,
  output logic              fiq_out
);
  logic [NLINE-1:0]         mask_flat, pend_flat, route_flat;
  logic [NLINE-1:0][PW-1:0] prio_flat;
  logic                     gmask, soft_rst;
  logic [1:0]               rearm;
  logic [1:0][NLINE-1:0]    cand;
  logic [1:0]               any, outs;
  logic [1:0][CW-1:0]       win, code;

  intc_regs #(.NBANK(NBANK), .LPB(LPB), .PW(PW), .REV(REV)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_en     (bus_en),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .lines_in   (src_lines),
    .code_irq   (code[CLS_IRQ]),
    .code_fiq   (code[CLS_FIQ]),
    .mask_flat  (mask_flat),
    .pend_flat  (pend_flat),
    .route_flat (route_flat),
    .prio_flat  (prio_flat),
    .gmask      (gmask),
    .rearm      (rearm),
    .soft_rst   (soft_rst)
  );

  assign cand[CLS_IRQ] = pend_flat & ~mask_flat & ~route_flat;
  assign cand[CLS_FIQ] = pend_flat & ~mask_flat &  route_flat;

  for (genvar k = 0; k < 2; k++) begin : g_cls
    intc_resolver #(.NLINE(NLINE), .PW(PW)) u_res (
      .clk   (clk),
      .rst_n (rst_n),
      .cand  (cand[k]),
      .prio  (prio_flat),
      .any   (any[k]),
      .win   (win[k])
    );

    intc_outctl #(.CW(CW)) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .rearm    (rearm[k]),
      .gmask    (gmask),
      .any      (any[k]),
      .win      (win[k]),
      .out_q    (outs[k]),
      .code_q   (code[k])
    );
  end

  assign irq_out = outs[CLS_IRQ];
  assign fiq_out = outs[CLS_FIQ];

  assert_classes_disjoint_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cand[CLS_IRQ] & cand[CLS_FIQ]) == '0);
endmodule

// File: tb/sim_mbk_intc.sv
`timescale 1ns/1ps
module sim_mbk_intc;
  localparam int NL = 96;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_en = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NL-1:0] lines = '0;
  logic        irq_out, fiq_out;

  always #2.5 clk = ~clk;

  mbk_intc u0 (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_lines(lines), .irq_out(irq_out), .fiq_out(fiq_out)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // bench-side model for the random phase
  logic [31:0] m_mask [3];
  logic [31:0] m_swi  [3];
  logic [5:0]  m_prio [NL];
  logic        m_route[NL];

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [11:0] ad, input logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = ad; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] ad, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = ad;
    #1;
    d = bus_rdata;
    bus_en = 1'b0;
  endtask

  function automatic logic [11:0] bk(input int b, input int off);
    return 12'(32'h080 + b * 32 + off);
  endfunction

  function automatic logic [11:0] cfga(input int line);
    return 12'(32'h100 + (line / 32) * 128 + (line % 32) * 4);
  endfunction

  function automatic logic [31:0] exp_view(input int b, input bit fast);
    logic [31:0] p, r;
    p = lines[b*32 +: 32] | m_swi[b];
    for (int n = 0; n < 32; n++) r[n] = m_route[b*32 + n];
    return fast ? (p & ~m_mask[b] & r) : (p & ~m_mask[b] & ~r);
  endfunction

  // descending scan with strict compare: highest line wins a tie
  task automatic exp_win(input bit fast, output bit found, output int idx);
    int best;
    best = 64; found = 0; idx = 0;
    for (int i = NL - 1; i >= 0; i--) begin
      bit c;
      c = (lines[i] | m_swi[i/32][i%32]) && !m_mask[i/32][i%32] && (m_route[i] == fast);
      if (c && int'(m_prio[i]) < best) begin
        best = int'(m_prio[i]); idx = i; found = 1;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd2024));
    tick(3);
    rst_n = 1'b1;
    tick(1);

    // ---- R1 reset state
    rd(12'h000, v); chk("R1", "revision", v, 32'h21);
    rd(12'h014, v); chk("R1", "status", v, 32'h1);
    for (int b = 0; b < 3; b++) begin
      rd(bk(b, 4), v); chk("R1", "mask after reset", v, 32'hFFFF_FFFF);
    end
    rd(cfga(17), v); chk("R1", "line config", v, 32'h0);
    rd(12'h040, v); chk("R1", "irq code", v, 32'h0);
    chk("R1", "outputs low", {30'd0, fiq_out, irq_out}, 32'h0);

    // ---- R2/R3/R6 software-set line 35 (bank 1 bit 3)
    wr(bk(1, 16), 32'h8);
    wr(bk(1, 8), 32'h8);
    rd(bk(1, 24), v); chk("R3", "pending irq view b1", v, 32'h8);
    tick(1);
    chk("R6", "irq fires", {31'd0, irq_out}, 32'h1);
    rd(12'h040, v); chk("R6", "irq code", v, 32'd35);
    rd(12'h040, v); chk("R11", "code reread", v, 32'd35);
    rd(bk(1, 20), v); chk("R2", "sw clear reads 0", v, 32'h0);
    wr(bk(1, 20), 32'h8);
    rd(bk(1, 24), v); chk("R2", "pending after sw clear", v, 32'h0);
    chk("R8", "irq held", {31'd0, irq_out}, 32'h1);
    wr(12'h048, 32'h1);
    chk("R8", "rearm drops irq", {31'd0, irq_out}, 32'h0);
    tick(2);
    chk("R8", "no refire without cand", {31'd0, irq_out}, 32'h0);

    // ---- R2/R7 live inputs, tie across banks
    wr(12'h048, 32'h4);
    lines[5] = 1'b1; lines[70] = 1'b1;
    wr(bk(0, 8), 32'h20);
    wr(bk(2, 8), 32'h40);
    rd(bk(0, 0), v); chk("R2", "raw b0", v, 32'h20);
    rd(bk(2, 0), v); chk("R2", "raw b2", v, 32'h40);
    wr(12'h048, 32'h3);
    tick(1);
    rd(12'h040, v); chk("R7", "tie -> higher line", v, 32'd70);
    wr(12'h048, 32'h4);
    wr(cfga(70), 32'h3 << 2);
    wr(12'h048, 32'h3);
    tick(1);
    rd(12'h040, v); chk("R7", "lower prio value wins", v, 32'd5);

    // ---- R3/R6 FIQ route on line 40
    wr(12'h048, 32'h4);
    wr(cfga(40), 32'h1);
    lines[40] = 1'b1;
    wr(bk(1, 8), 32'h100);
    wr(12'h048, 32'h3);
    tick(1);
    chk("R6", "fiq fires", {31'd0, fiq_out}, 32'h1);
    rd(12'h044, v); chk("R6", "fiq code", v, 32'd40);
    rd(bk(1, 28), v); chk("R3", "pending fiq view b1", v, 32'h100);
    rd(bk(1, 24), v); chk("R3", "pending irq view b1", v, 32'h0);
    rd(cfga(40), v); chk("R5", "route readback", v, 32'h1);

    // ---- R9 global mask
    wr(12'h048, 32'h7);
    tick(2);
    chk("R9", "gmask blocks both", {30'd0, fiq_out, irq_out}, 32'h0);
    rd(12'h048, v); chk("R9", "gmask readback", v, 32'h4);
    wr(12'h048, 32'h3);
    tick(1);
    chk("R9", "release fires both", {30'd0, fiq_out, irq_out}, 32'h3);

    // ---- R4 mask aliases
    wr(bk(0, 12), 32'h20);
    rd(bk(0, 4), v); chk("R4", "mask set alias", v, 32'hFFFF_FFFF);
    rd(bk(0, 24), v); chk("R4", "masked view", v, 32'h0);
    rd(bk(0, 8), v); chk("R4", "mask clear reads 0", v, 32'h0);
    rd(bk(0, 12), v); chk("R4", "mask set reads 0", v, 32'h0);
    wr(bk(0, 4), 32'h0000_FFFF);
    rd(bk(0, 4), v); chk("R4", "mask load", v, 32'h0000_FFFF);

    // ---- R11 ignored accesses
    wr(12'h0E4, 32'h0);
    rd(12'h0E4, v); chk("R11", "bank3 reads 0", v, 32'h0);
    rd(bk(0, 4), v); chk("R11", "bank0 mask untouched", v, 32'h0000_FFFF);
    rd(bk(2, 4), v); chk("R11", "bank2 mask untouched", v, 32'hFFFF_FFBF);
    wr(12'h000, 32'h0);
    rd(12'h000, v); chk("R11", "revision read-only", v, 32'h21);
    wr(12'h040, 32'h0);
    rd(12'h040, v); chk("R11", "code read-only", v, 32'd5);
    wr(bk(0, 0), 32'h0);
    rd(bk(0, 0), v); chk("R11", "raw read-only", v, 32'h20);
    rd(12'h280, v); chk("R11", "config past last bank", v, 32'h0);

    // ---- R5 config field packing
    wr(cfga(95), 32'hFF);
    rd(12'h27C, v); chk("R5", "line95 config", v, 32'hFD);

    // ---- R12 misc words
    wr(12'h010, 32'h1);
    rd(12'h010, v); chk("R12", "autoidle", v, 32'h1);
    wr(12'h050, 32'hF);
    rd(12'h050, v); chk("R12", "idle 2 bits", v, 32'h3);
    wr(12'h04C, 32'h1);
    rd(12'h04C, v); chk("R12", "protection", v, 32'h0);

    // ---- R10 soft reset
    wr(12'h010, 32'h2);
    rd(bk(1, 4), v); chk("R10", "mask restored", v, 32'hFFFF_FFFF);
    rd(12'h27C, v); chk("R10", "config cleared", v, 32'h0);
    rd(12'h010, v); chk("R10", "sysconfig cleared", v, 32'h0);
    rd(12'h050, v); chk("R10", "idle cleared", v, 32'h0);
    rd(12'h040, v); chk("R10", "code cleared", v, 32'h0);
    rd(12'h048, v); chk("R10", "control cleared", v, 32'h0);
    chk("R10", "outputs low", {30'd0, fiq_out, irq_out}, 32'h0);

    // ---- random phase: R2 R3 R6 R7
    for (int b = 0; b < 3; b++) begin m_mask[b] = '1; m_swi[b] = '0; end
    for (int i = 0; i < NL; i++) begin m_prio[i] = '0; m_route[i] = 1'b0; end
    for (int it = 0; it < 30; it++) begin
      bit   fnd;
      int   widx;
      wr(12'h048, 32'h4);
      lines = {$urandom(), $urandom(), $urandom()};
      for (int b = 0; b < 3; b++) begin
        logic [31:0] sw, sc;
        m_mask[b] = $urandom() | $urandom();
        wr(bk(b, 4), m_mask[b]);
        sw = $urandom() & $urandom() & $urandom();
        sc = $urandom();
        wr(bk(b, 20), 32'hFFFF_FFFF);
        wr(bk(b, 16), sw);
        wr(bk(b, 20), sc);
        m_swi[b] = sw & ~sc;
      end
      for (int i = 0; i < NL; i++) begin
        m_prio[i]  = 6'($urandom_range(0, 3));
        m_route[i] = 1'($urandom_range(0, 1));
        wr(cfga(i), {24'd0, m_prio[i], 1'b0, m_route[i]});
      end
      for (int b = 0; b < 3; b++) begin
        rd(bk(b, 0), v);  chk("R2", "random raw", v, lines[b*32 +: 32]);
        rd(bk(b, 24), v); chk("R3", "random irq view", v, exp_view(b, 1'b0));
        rd(bk(b, 28), v); chk("R3", "random fiq view", v, exp_view(b, 1'b1));
      end
      wr(12'h048, 32'h3);
      tick(1);
      exp_win(1'b0, fnd, widx);
      chk("R6", "random irq out", {31'd0, irq_out}, {31'd0, fnd});
      if (fnd) begin rd(12'h040, v); chk("R7", "random irq winner", v, 32'(widx)); end
      exp_win(1'b1, fnd, widx);
      chk("R6", "random fiq out", {31'd0, fiq_out}, {31'd0, fnd});
      if (fnd) begin rd(12'h044, v); chk("R7", "random fiq winner", v, 32'(widx)); end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule